// File: doc/BRIEF.md
# 8-bit ALU with Per-Flag Status Update

This block is the arithmetic/logic datapath of a small 8-bit microcontroller core. Each cycle it takes an operation code, a first operand, a second operand picked from either a register value or an 8-bit immediate, and the carry and zero bits of its own status register. It produces the 8-bit result, a candidate value for each of six status flags (carry, zero, negative, overflow, sign, half carry) and a six-bit write mask. The mask says which flags the operation defines.

A thin clocked wrapper holds the status register. When `exec_en` is high at a rising clock edge, only the flags whose mask bit is set take their new value. Every other flag keeps its old value. This lets a sequence of operations be checked, for example a multi-byte subtract chain in which the zero flag carries across bytes, or a loop counter that must not disturb the carry.

Operation codes on `op_sel`: 0 add, 1 add with carry, 2 subtract, 3 subtract with carry, 4 AND, 5 OR, 6 XOR, 7 one's complement, 8 negate, 9 increment, 10 decrement. Codes 11 to 15 are reserved. Flag bit positions in `flags_next`, `flag_we` and `status`: 0 C, 1 Z, 2 N, 3 V, 4 S, 5 H.

Top module: `alu8_core`

## Requirements
- R1: The result is A+B (code 0), A+B+C (1), A−B (2), A−B−C (3), A&B (4), A|B (5), A^B (6), ~A (7), 0−A (8), A+1 (9) and A−1 (10), all modulo 256. B is `imm_b` when `use_imm` is 1 and `reg_b` otherwise.
- R2: Codes 0 and 1 set C when the unsigned sum exceeds 255. They set H on a carry out of bit 3 and V on signed overflow. They write all six flags (mask 6'b111111).
- R3: Codes 2 and 3 set C when the subtrahend plus the incoming borrow exceeds A as unsigned values. They set H on a borrow from bit 4 and V on signed overflow. They write all six flags.
- R4: In every written set, N is result bit 7 and S is N XOR V. Z is 1 exactly when the result is zero, except for code 3.
- R5: Code 3 gives Z = 1 only when the result is zero and the previous Z was 1, so Z chains across multi-byte subtraction.
- R6: Codes 4, 5 and 6 force V to 0 and write only Z, N, V and S (mask 6'b011110). C and H in the status register stay unchanged.
- R7: Code 7 sets C to 1 and V to 0. It writes C, Z, N, V and S (mask 6'b011111) and leaves H unchanged.
- R8: Code 8 uses the subtract flag rules with 0 as minuend. An input of 0x80 yields 0x80 with V=1 and C=1, and an input of 0 yields C=0.
- R9: Code 9 sets V only when the result is 0x80, and code 10 sets V only when the result is 0x7F. Both write only Z, N, V and S.
- R10: The status register resets to 0 on a synchronous active-low reset. It updates only masked flags when `exec_en` is high and holds otherwise. Codes 11 to 15 give mask 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exec_en | input | 1 | Commit the masked flags to the status register at this edge |
| op_sel | input | 4 | Operation code |
| use_imm | input | 1 | Select `imm_b` as second operand |
| opnd_a | input | 8 | First operand |
| reg_b | input | 8 | Register second operand |
| imm_b | input | 8 | Immediate second operand |
| result | output | 8 | Operation result |
| flags_next | output | 6 | Candidate flag values {H,S,V,N,Z,C} |
| flag_we | output | 6 | Per-flag write mask |
| status | output | 6 | Latched status register |

## Verification
The hardest state to reach from the ports is the sticky zero flag of subtract with carry. It only shows when a zero result follows a prior Z of 1 on one path and of 0 on another, and random operands almost never give a zero result. Directed chains therefore first set or clear Z with a plain subtract, then run subtract-with-carry on equal operands with the carry in a known state. A random phase then drives long mixed sequences against a bench model that tracks its own status register. That phase also covers held carry and half carry through logic, increment and decrement steps.

// File: rtl/alu8_pkg.sv
// Shared operation codes and flag bit positions for the 8-bit ALU.
package alu8_pkg;

    typedef enum logic [3:0] {
        OPC_ADD = 4'd0,
        OPC_ADC = 4'd1,
        OPC_SUB = 4'd2,
        OPC_SBC = 4'd3,
        OPC_AND = 4'd4,
        OPC_OR  = 4'd5,
        OPC_XOR = 4'd6,
        OPC_COM = 4'd7,
        OPC_NEG = 4'd8,
        OPC_INC = 4'd9,
        OPC_DEC = 4'd10
    } alu_op_e;

    localparam int FLG_C = 0;
    localparam int FLG_Z = 1;
    localparam int FLG_N = 2;
    localparam int FLG_V = 3;
    localparam int FLG_S = 4;
    localparam int FLG_H = 5;
    localparam int FLG_W = 6;

    typedef logic [FLG_W-1:0] flag_vec_t;

    // Write masks per operation class
    localparam flag_vec_t WE_ALL   = 6'b111111;
    localparam flag_vec_t WE_ZNVS  = 6'b011110;
    localparam flag_vec_t WE_CZNVS = 6'b011111;
    localparam flag_vec_t WE_NONE  = 6'b000000;

    // Logic unit function select
    typedef enum logic [1:0] {
        LF_AND = 2'd0,
        LF_OR  = 2'd1,
        LF_XOR = 2'd2,
        LF_NOT = 2'd3
    } logic_fn_e;

endpackage

// File: rtl/alu8_arith.sv
// Adder/subtractor with carry-in and carry, half-carry and overflow outputs.
// Assumes W >= 5 so that the half-carry bit (bit 3) exists.
// Flags are derived from the operands and the final result, so a carry-in
// is folded in without a separate carry chain.
module alu8_arith #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         is_sub,
    output logic [W-1:0] r,
    output logic         c_out,
    output logic         h_out,
    output logic         v_out
);
    localparam int MSB  = W - 1;
    localparam int HBIT = 3;

    logic [W-1:0] cin_ext;
    logic [W-1:0] carry_vec;
    logic [W-1:0] borrow_vec;
    logic [W-1:0] ovf_add_vec;
    logic [W-1:0] ovf_sub_vec;

    assign cin_ext = {{(W-1){1'b0}}, cin};

    // Sum or difference, including the incoming carry/borrow
    always_comb begin
        if (is_sub) r = a - b - cin_ext;
        else        r = a + b + cin_ext;
    end

    // Per-bit carry and borrow out vectors from operands and result
    always_comb begin
        carry_vec   = (a & b) | (a & ~r) | (b & ~r);
        borrow_vec  = (~a & b) | (~a & r) | (r & b);
        ovf_add_vec = (a ^ r) & ~(a ^ b);
        ovf_sub_vec = (a ^ r) & (a ^ b);
    end

    // Select the flag taps for the active direction
    always_comb begin
        if (is_sub) begin
            c_out = borrow_vec[MSB];
            h_out = borrow_vec[HBIT];
            v_out = ovf_sub_vec[MSB];
        end else begin
            c_out = carry_vec[MSB];
            h_out = carry_vec[HBIT];
            v_out = ovf_add_vec[MSB];
        end
    end
endmodule

// File: rtl/alu8_logic.sv
// Bitwise unit: AND, OR, XOR or one's complement of the first operand.
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic_fn_e    fn,
    output logic [W-1:0] r
);
    // Select the bitwise function
    always_comb begin
        unique case (fn)
            LF_AND:  r = a & b;
            LF_OR:   r = a | b;
            LF_XOR:  r = a ^ b;
            default: r = ~a;
        endcase
    end
endmodule

// File: rtl/alu8_step.sv
// Increment/decrement by one. Overflow is flagged by matching the result
// against the single value that signals a signed wrap in each direction.
module alu8_step #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic         down,
    output logic [W-1:0] r,
    output logic         v_out
);
    localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

    // Step the value and detect signed wrap
    always_comb begin
        if (down) begin
            r     = a - ONE;
            v_out = (r == MOST_POS);
        end else begin
            r     = a + ONE;
            v_out = (r == MOST_NEG);
        end
    end
endmodule

// File: rtl/alu8_flagmux.sv
// Picks the result and builds the flag candidates and write mask per
// operation. Assumes the arith, logic and step units already see the
// operands the top module steered to them.
module alu8_flagmux
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [3:0]   op_code,
    input  logic [W-1:0] a,
    input  logic [W-1:0] arith_r,
    input  logic         arith_c,
    input  logic         arith_h,
    input  logic         arith_v,
    input  logic [W-1:0] logic_r,
    input  logic [W-1:0] step_r,
    input  logic         step_v,
    input  logic         z_prev,
    output logic [W-1:0] res,
    output flag_vec_t    flags,
    output flag_vec_t    we
);
    localparam int MSB = W - 1;

    logic c_f, z_f, v_f, h_f, n_f;
    logic res_zero;

    assign res_zero = (res == '0);
    assign n_f      = res[MSB];

    // Route result, carry, half carry, overflow and mask by operation
    always_comb begin
        res = a;
        c_f = 1'b0;
        h_f = 1'b0;
        v_f = 1'b0;
        we  = WE_NONE;
        case (op_code)
            OPC_ADD, OPC_ADC, OPC_SUB, OPC_SBC, OPC_NEG: begin
                res = arith_r;
                c_f = arith_c;
                h_f = arith_h;
                v_f = arith_v;
                we  = WE_ALL;
            end
            OPC_AND, OPC_OR, OPC_XOR: begin
                res = logic_r;
                we  = WE_ZNVS;
            end
            OPC_COM: begin
                res = logic_r;
                c_f = 1'b1;
                we  = WE_CZNVS;
            end
            OPC_INC, OPC_DEC: begin
                res = step_r;
                v_f = step_v;
                we  = WE_ZNVS;
            end
            default: begin
                res = a;
                we  = WE_NONE;
            end
        endcase
    end

    // Zero flag: sticky for subtract with carry, plain otherwise
    always_comb begin
        if (op_code == OPC_SBC) z_f = res_zero & z_prev;
        else                    z_f = res_zero;
    end

    // Pack the flag vector
    always_comb begin
        flags        = '0;
        flags[FLG_C] = c_f;
        flags[FLG_Z] = z_f;
        flags[FLG_N] = n_f;
        flags[FLG_V] = v_f;
        flags[FLG_S] = n_f ^ v_f;
        flags[FLG_H] = h_f;
    end
endmodule

// File: rtl/alu8_core.sv
// Top of the 8-bit ALU. Steers operands to the arithmetic, logic and step
// units, forms result and flag candidates combinationally, and keeps a
// status register that takes only the masked flags when exec_en is high.
// Assumes op_sel and operands are stable around the rising edge.
module alu8_core
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         exec_en,
    input  logic [3:0]   op_sel,
    input  logic         use_imm,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] reg_b,
    input  logic [W-1:0] imm_b,
    output logic [W-1:0] result,
    output logic [5:0]   flags_next,
    output logic [5:0]   flag_we,
    output logic [5:0]   status
);
    logic [W-1:0] b_sel;
    logic [W-1:0] ar_a, ar_b, ar_r, lg_r, st_r;
    logic         ar_cin, ar_sub, ar_c, ar_h, ar_v, st_v;
    logic_fn_e    lg_fn;
    flag_vec_t    fl_cand, fl_we;
    flag_vec_t    status_q;

    assign b_sel = use_imm ? imm_b : reg_b;

    // Steer operands, carry-in and direction into the adder/subtractor
    always_comb begin
        ar_a   = opnd_a;
        ar_b   = b_sel;
        ar_cin = 1'b0;
        ar_sub = 1'b0;
        case (op_sel)
            OPC_ADC: ar_cin = status_q[FLG_C];
            OPC_SUB: ar_sub = 1'b1;
            OPC_SBC: begin
                ar_sub = 1'b1;
                ar_cin = status_q[FLG_C];
            end
            OPC_NEG: begin
                ar_a   = '0;
                ar_b   = opnd_a;
                ar_sub = 1'b1;
            end
            default: ;
        endcase
    end

    // Map the operation code to a bitwise function
    always_comb begin
        case (op_sel)
            OPC_AND: lg_fn = LF_AND;
            OPC_OR:  lg_fn = LF_OR;
            OPC_XOR: lg_fn = LF_XOR;
            default: lg_fn = LF_NOT;
        endcase
    end

    alu8_arith #(.W(W)) u_arith (
        .a      (ar_a),
        .b      (ar_b),
        .cin    (ar_cin),
        .is_sub (ar_sub),
        .r      (ar_r),
        .c_out  (ar_c),
        .h_out  (ar_h),
        .v_out  (ar_v)
    );

    alu8_logic #(.W(W)) u_logic (
        .a  (opnd_a),
        .b  (b_sel),
        .fn (lg_fn),
        .r  (lg_r)
    );

    alu8_step #(.W(W)) u_step (
        .a     (opnd_a),
        .down  (op_sel == OPC_DEC),
        .r     (st_r),
        .v_out (st_v)
    );

    alu8_flagmux #(.W(W)) u_fmux (
        .op_code (op_sel),
        .a       (opnd_a),
        .arith_r (ar_r),
        .arith_c (ar_c),
        .arith_h (ar_h),
        .arith_v (ar_v),
        .logic_r (lg_r),
        .step_r  (st_r),
        .step_v  (st_v),
        .z_prev  (status_q[FLG_Z]),
        .res     (result),
        .flags   (fl_cand),
        .we      (fl_we)
    );

    // Status register: masked per-flag update, synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n)       status_q <= '0;
        else if (exec_en) status_q <= (status_q & ~fl_we) | (fl_cand & fl_we);
    end

    assign flags_next = fl_cand;
    assign flag_we    = fl_we;
    assign status     = status_q;
endmodule

// File: rtl/alu8_chk.sv
// Property checker for alu8_core, attached by bind.
module alu8_chk
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         exec_en,
    input logic [3:0]   op_sel,
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] result,
    input logic [5:0]   flags_next,
    input logic [5:0]   flag_we,
    input logic [5:0]   status
);
    AST_SBC_Z_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OPC_SBC && !status[FLG_Z]) |-> !flags_next[FLG_Z]); // R5

    AST_LOGIC_KEEPS_CH: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OPC_AND || op_sel == OPC_OR || op_sel == OPC_XOR)
        |-> (!flag_we[FLG_C] && !flag_we[FLG_H] && !flags_next[FLG_V])); // R6

    AST_COM_SETS_C: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OPC_COM) |-> (flags_next[FLG_C] && result == ~opnd_a)); // R7

    AST_STEP_HOLDS_C: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && (op_sel == OPC_INC || op_sel == OPC_DEC))
        |=> (status[FLG_C] == $past(status[FLG_C]) && status[FLG_H] == $past(status[FLG_H]))); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_en |=> $stable(status)); // R10

    AST_Z_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && flag_we[FLG_Z]) |=> status[FLG_Z] == $past(flags_next[FLG_Z])); // R10

    AST_RESERVED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel > 4'd10) |-> (flag_we == 6'b000000)); // R10
endmodule

bind alu8_core alu8_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .exec_en    (exec_en),
    .op_sel     (op_sel),
    .opnd_a     (opnd_a),
    .result     (result),
    .flags_next (flags_next),
    .flag_we    (flag_we),
    .status     (status)
);

// File: tb/tb_alu8_core.sv
module tb_alu8_core;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       exec_en;
    logic [3:0] op_sel;
    logic       use_imm;
    logic [7:0] opnd_a, reg_b, imm_b;
    logic [7:0] result;
    logic [5:0] flags_next, flag_we, status;

    int checks = 0;
    int errors = 0;
    logic [5:0] m_status;
    bit done = 0;

    always #4 clk = ~clk;

    alu8_core dut (
        .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .op_sel(op_sel),
        .use_imm(use_imm), .opnd_a(opnd_a), .reg_b(reg_b), .imm_b(imm_b),
        .result(result), .flags_next(flags_next), .flag_we(flag_we),
        .status(status)
    );

    // Reference model from the requirements; flag order {H,S,V,N,Z,C}
    function automatic void model(input logic [3:0] op, input logic [7:0] a,
                                  input logic [7:0] b, input logic [5:0] st,
                                  output logic [7:0] r, output logic [5:0] f,
                                  output logic [5:0] we);
        int ci, sa, sb, full;
        logic c, z, n, v, h;
        ci = int'(st[0]);
        sa = int'($signed(a));
        sb = int'($signed(b));
        c = 0; v = 0; h = 0; r = a; we = 6'b000000;
        case (op)
            4'd0, 4'd1: begin
                if (op == 4'd0) ci = 0;
                full = int'(a) + int'(b) + ci;
                r = full[7:0];
                c = full > 255;
                h = (int'(a[3:0]) + int'(b[3:0]) + ci) > 15;
                v = (sa + sb + ci > 127) || (sa + sb + ci < -128);
                we = 6'b111111;
            end
            4'd2, 4'd3, 4'd8: begin
                int ma, sma;
                logic [7:0] mb;
                if (op != 4'd3) ci = 0;
                if (op == 4'd8) begin ma = 0; sma = 0; mb = a; sb = sa; end
                else begin ma = int'(a); sma = sa; mb = b; end
                full = ma - int'(mb) - ci;
                r = full[7:0];
                c = int'(mb) + ci > ma;
                h = int'(mb[3:0]) + ci > (ma % 16);
                v = (sma - sb - ci > 127) || (sma - sb - ci < -128);
                we = 6'b111111;
            end
            4'd4: begin r = a & b; we = 6'b011110; end
            4'd5: begin r = a | b; we = 6'b011110; end
            4'd6: begin r = a ^ b; we = 6'b011110; end
            4'd7: begin r = ~a; c = 1; we = 6'b011111; end
            4'd9: begin r = a + 8'd1; v = (r == 8'h80); we = 6'b011110; end
            4'd10: begin r = a - 8'd1; v = (r == 8'h7F); we = 6'b011110; end
            default: ;
        endcase
        z = (r == 8'h00);
        if (op == 4'd3) z = z && st[1];
        n = r[7];
        f = {h, n ^ v, v, n, z, c};
    endfunction

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd0, 4'd1: return "R2";
            4'd2: return "R3";
            4'd3: return "R5";
            4'd4, 4'd5, 4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            4'd9, 4'd10: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Apply one operation, check combinational outputs, then the status
    task automatic run_op(input logic [3:0] op, input logic [7:0] a,
                          input logic [7:0] b, input logic imm, input logic en);
        logic [7:0] er;
        logic [5:0] ef, ewe;
        @(negedge clk);
        op_sel = op; opnd_a = a; use_imm = imm; exec_en = en;
        if (imm) begin imm_b = b; reg_b = ~b; end
        else begin reg_b = b; imm_b = ~b; end
        #1;
        model(op, a, b, m_status, er, ef, ewe);
        if (op <= 4'd10) check("R1", "result", result, er);
        check(req_of(op), "mask", {2'b00, flag_we}, {2'b00, ewe});
        check((op == 4'd3) ? "R5" : "R4", "flags", {2'b00, flags_next & ewe},
              {2'b00, ef & ewe});
        if (en) m_status = (m_status & ~ewe) | (ef & ewe);
        @(posedge clk);
        #1;
        check("R10", "status", {2'b00, status}, {2'b00, m_status});
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; exec_en = 0; op_sel = 0; use_imm = 0;
        opnd_a = 0; reg_b = 0; imm_b = 0; m_status = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R10", "reset status", {2'b00, status}, 8'h00);
        @(negedge clk); rst_n = 1;

        // R2 add corners
        run_op(4'd0, 8'h7F, 8'h01, 0, 1);   // V and H set
        run_op(4'd0, 8'hFF, 8'h01, 1, 1);   // C, Z, H via immediate
        run_op(4'd1, 8'h00, 8'h00, 0, 1);   // carry-in gives 1
        // R3 subtract borrow
        run_op(4'd2, 8'h00, 8'h01, 1, 1);
        run_op(4'd2, 8'h80, 8'h01, 0, 1);
        // R5 sticky zero chain
        run_op(4'd2, 8'h05, 8'h05, 0, 1);   // Z=1, C=0
        run_op(4'd3, 8'h00, 8'h00, 0, 1);   // zero result keeps Z=1
        check("R5", "sticky Z kept", {7'b0, status[1]}, 8'h01);
        run_op(4'd2, 8'h03, 8'h05, 0, 1);   // Z=0, C=1
        run_op(4'd3, 8'h01, 8'h00, 1, 1);   // 1-0-1=0 but Z stays 0
        check("R5", "sticky Z clear", {7'b0, status[1]}, 8'h00);
        // R6 logic keeps C and H
        run_op(4'd0, 8'h0F, 8'hF1, 0, 1);   // C=1, H=1
        run_op(4'd4, 8'hF0, 8'h0F, 0, 1);
        run_op(4'd5, 8'h80, 8'h01, 1, 1);
        run_op(4'd6, 8'hAA, 8'hAA, 0, 1);
        check("R6", "C,H held", {6'b0, status[5], status[0]}, 8'h03);
        // R7 complement
        run_op(4'd7, 8'hFF, 8'h00, 0, 1);
        // R8 negate corners
        run_op(4'd8, 8'h80, 8'h00, 0, 1);
        check("R8", "neg 0x80", result, 8'h80);
        run_op(4'd8, 8'h00, 8'h00, 0, 1);
        run_op(4'd8, 8'h01, 8'h00, 0, 1);
        // R9 inc/dec wrap
        run_op(4'd9, 8'h7F, 8'h00, 0, 1);
        run_op(4'd10, 8'h80, 8'h00, 0, 1);
        run_op(4'd9, 8'hFF, 8'h00, 0, 1);
        // R10 reserved codes and idle
        run_op(4'd12, 8'h00, 8'h00, 0, 1);
        run_op(4'd0, 8'hFF, 8'hFF, 0, 0);

        for (int i = 0; i < 3000; i++) begin
            logic [3:0] op;
            op = 4'($urandom_range(0, 15));
            run_op(op, 8'($urandom), 8'($urandom), 1'($urandom),
                   ($urandom_range(0, 7) != 0));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule